// File: doc/BRIEF.md
# Settings Persistence Sequencer

This block holds the live copy of three small settings of a dual attenuator: the tap code of channel A, the tap code of channel B and a control byte. A bus front end hands it accepted command bytes and a pulse when the bus transaction ends. The block updates the live copy at once. It then decides whether the live copy must be copied into a slow persistent store, and when that copy may start.

The persistent store is modelled inside the block as a register bank. Its write time is a parameter counted in clock cycles. While a copy is waiting or running, `busy_o` is high, and the front end uses it to refuse its own device address. While the block is busy it drops any command byte it receives. Every copy rewrites all three stored fields.

`rst` models power-up. On power-up the live copy is loaded from the store when the store holds valid data, and from factory values otherwise. `blank_i` marks the store as holding no valid data.

Top module: `persist_seq`

## Requirements
- R1: With a blank store, reset gives control byte 0x87, both tap codes 33 and `busy_o` low.
- R2: An accepted command byte takes effect on the next clock, decoded by its bits [7:6]. 00 sets tap A to bits [5:0]. 01 sets tap B to bits [5:0]. 10 sets the control byte to {2'b10, 3'b000, bits [2:0]}. 11 changes nothing.
- R3: Take an end-of-transaction pulse after a tap write, with control bit 2 = 0 (persistent) and control bit 1 = 0. `busy_o` rises on the next clock and stays high for exactly BUSY_CYC cycles.
- R4: With control bit 2 = 1 (volatile), an end pulse after only tap writes leaves `busy_o` low and starts no copy.
- R5: With control bit 1 = 1 (zero-cross wait on), an end pulse that arrives while `zc_wait_i` is high holds `busy_o` high without starting the write timer. The BUSY_CYC write cycles begin once `zc_wait_i` is low.
- R6: A copy stores all three fields, so a later reset restores the control byte and both tap codes exactly.
- R7: A command byte presented while `busy_o` is high is ignored.
- R8: An end pulse with no accepted tap or control write since the previous end pulse leaves `busy_o` low. Reserved commands do not count as writes.
- R9: On reset with a valid store whose control bit 2 = 1, both taps load the mute code: 63 when control bit 0 = 0, 33 when it is 1. The control byte loads as stored.
- R10: With control bit 1 = 0, `zc_wait_i` has no effect on the copy duration.
- R11: A write to the control byte always leads to a copy at the next end pulse, even in volatile mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset; reloads the live copy |
| blank_i | input | 1 | Marks the persistent store as holding no valid data |
| wr_i | input | 1 | Command byte strobe from the bus front end |
| wr_cmd_i | input | 8 | Command byte |
| stop_i | input | 1 | One-cycle pulse marking the end of a bus transaction |
| zc_wait_i | input | 1 | High while a zero-crossing wait is still pending |
| busy_o | output | 1 | Copy pending or running; the address must not be acknowledged |
| wiper0_o | output | 6 | Live tap code, channel A |
| wiper1_o | output | 6 | Live tap code, channel B |
| cfg_o | output | 8 | Live control byte |

## Verification
The bound checker watches four things on every cycle. A busy period only begins right after an end pulse. The live settings are frozen during the cycle after any busy cycle. A store write is always the last busy cycle. Reserved commands leave every setting alone.

Other behaviour depends on history and can only be shown by the bench's scenarios. This covers the exact busy length, the extra hold under a pending zero-cross wait, the volatile-mode skip of tap-only copies, and the power-up reload of stored or mute values. The bench compares every clock against a behavioural model to cover these.

// File: rtl/persist_pkg.sv
package persist_pkg;

    localparam int WIPER_W  = 6;
    localparam int CTL_W    = 3;
    localparam int CTL_VOL  = 2;
    localparam int CTL_ZC   = 1;
    localparam int CTL_OPT  = 0;

    localparam logic [WIPER_W-1:0] MUTE_FINE   = WIPER_W'(63);
    localparam logic [WIPER_W-1:0] MUTE_COARSE = WIPER_W'(33);
    localparam logic [CTL_W-1:0]   CTL_FACTORY = 3'b111;

    typedef enum logic [1:0] {
        CMD_TAP_A = 2'b00,
        CMD_TAP_B = 2'b01,
        CMD_CTL   = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ZC_HOLD = 2'd1,
        ST_WRITE   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [CTL_W-1:0]   ctl;
        logic [WIPER_W-1:0] tap_b;
        logic [WIPER_W-1:0] tap_a;
    } setting_t;

    function automatic logic [WIPER_W-1:0] mute_code(input logic coarse);
        return coarse ? MUTE_COARSE : MUTE_FINE;
    endfunction

    function automatic logic [7:0] ctl_byte(input logic [CTL_W-1:0] c);
        return {2'b10, {(8-2-CTL_W){1'b0}}, c};
    endfunction

    function automatic setting_t boot_image(input logic valid, input setting_t s);
        setting_t r;
        if (!valid) begin
            r.ctl   = CTL_FACTORY;
            r.tap_a = mute_code(CTL_FACTORY[CTL_OPT]);
            r.tap_b = mute_code(CTL_FACTORY[CTL_OPT]);
        end else begin
            r.ctl = s.ctl;
            if (s.ctl[CTL_VOL]) begin
                r.tap_a = mute_code(s.ctl[CTL_OPT]);
                r.tap_b = mute_code(s.ctl[CTL_OPT]);
            end else begin
                r.tap_a = s.tap_a;
                r.tap_b = s.tap_b;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/persist_nvbank.sv
module persist_nvbank
    import persist_pkg::*;
(
    input  logic     clk,
    input  logic     blank_i,
    input  logic     we_i,
    input  setting_t din_i,
    output setting_t dout_o,
    output logic     valid_o
);
    setting_t cells;
    logic     filled;

    always_ff @(posedge clk) begin
        if (blank_i) begin
            filled <= 1'b0;
        end else if (we_i) begin
            filled <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells <= din_i;
        end
    end

    assign dout_o  = cells;
    assign valid_o = filled;
endmodule

// File: rtl/persist_regs.sv
module persist_regs
    import persist_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  setting_t   boot_i,
    input  logic       wr_i,
    input  logic [7:0] wr_cmd_i,
    input  logic       busy_i,
    output setting_t   live_o,
    output logic       hit_tap_o,
    output logic       hit_ctl_o
);
    setting_t  live_q;
    setting_t  live_d;
    cmd_kind_e kind;
    logic      accept;

    always_comb begin
        kind      = cmd_kind_e'(wr_cmd_i[7:6]);
        accept    = wr_i && !busy_i;
        live_d    = live_q;
        hit_tap_o = 1'b0;
        hit_ctl_o = 1'b0;
        if (accept) begin
            unique case (kind)
                CMD_TAP_A: begin
                    live_d.tap_a = wr_cmd_i[WIPER_W-1:0];
                    hit_tap_o    = 1'b1;
                end
                CMD_TAP_B: begin
                    live_d.tap_b = wr_cmd_i[WIPER_W-1:0];
                    hit_tap_o    = 1'b1;
                end
                CMD_CTL: begin
                    live_d.ctl = wr_cmd_i[CTL_W-1:0];
                    hit_ctl_o  = 1'b1;
                end
                CMD_RSVD: begin
                    live_d = live_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= boot_i;
        end else begin
            live_q <= live_d;
        end
    end

    assign live_o = live_q;
endmodule

// File: rtl/persist_ctrl.sv
module persist_ctrl
    import persist_pkg::*;
#(
    parameter int BUSY_CYC = 500_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_i,
    input  logic             zc_wait_i,
    input  logic [CTL_W-1:0] ctl_i,
    input  logic             hit_tap_i,
    input  logic             hit_ctl_i,
    output logic             busy_o,
    output logic             commit_o
);
    localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             tap_dirty_q, ctl_dirty_q;
    logic             tap_dirty, ctl_dirty;
    logic             need_copy;
    logic             zc_block;

    always_comb begin
        tap_dirty = tap_dirty_q || hit_tap_i;
        ctl_dirty = ctl_dirty_q || hit_ctl_i;
        need_copy = ctl_dirty || (tap_dirty && !ctl_i[CTL_VOL]);
        zc_block  = ctl_i[CTL_ZC] && zc_wait_i;
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        commit_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_i && need_copy) begin
                    cnt_d   = CNT_LAST;
                    state_d = zc_block ? ST_ZC_HOLD : ST_WRITE;
                end
            end
            ST_ZC_HOLD: begin
                if (!zc_block) begin
                    cnt_d   = CNT_LAST;
                    state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (cnt_q == '0) begin
                    commit_o = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            tap_dirty_q <= 1'b0;
            ctl_dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (stop_i) begin
                tap_dirty_q <= 1'b0;
                ctl_dirty_q <= 1'b0;
            end else begin
                tap_dirty_q <= tap_dirty;
                ctl_dirty_q <= ctl_dirty;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/persist_seq.sv
module persist_seq
    import persist_pkg::*;
#(
    parameter int BUSY_CYC = 500_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               blank_i,
    input  logic               wr_i,
    input  logic [7:0]         wr_cmd_i,
    input  logic               stop_i,
    input  logic               zc_wait_i,
    output logic               busy_o,
    output logic [WIPER_W-1:0] wiper0_o,
    output logic [WIPER_W-1:0] wiper1_o,
    output logic [7:0]         cfg_o
);
    setting_t live;
    setting_t stored;
    setting_t boot;
    logic     stored_ok;
    logic     commit;
    logic     busy;
    logic     hit_tap;
    logic     hit_ctl;

    assign boot = boot_image(stored_ok, stored);

    persist_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .boot_i    (boot),
        .wr_i      (wr_i),
        .wr_cmd_i  (wr_cmd_i),
        .busy_i    (busy),
        .live_o    (live),
        .hit_tap_o (hit_tap),
        .hit_ctl_o (hit_ctl)
    );

    persist_ctrl #(.BUSY_CYC(BUSY_CYC)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .stop_i    (stop_i),
        .zc_wait_i (zc_wait_i),
        .ctl_i     (live.ctl),
        .hit_tap_i (hit_tap),
        .hit_ctl_i (hit_ctl),
        .busy_o    (busy),
        .commit_o  (commit)
    );

    persist_nvbank u_bank (
        .clk     (clk),
        .blank_i (blank_i),
        .we_i    (commit),
        .din_i   (live),
        .dout_o  (stored),
        .valid_o (stored_ok)
    );

    assign busy_o   = busy;
    assign wiper0_o = live.tap_a;
    assign wiper1_o = live.tap_b;
    assign cfg_o    = ctl_byte(live.ctl);
endmodule

// File: rtl/persist_chk.sv
module persist_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_i,
    input logic [7:0] wr_cmd_i,
    input logic       stop_i,
    input logic       busy_o,
    input logic [5:0] wiper0_o,
    input logic [5:0] wiper1_o,
    input logic [7:0] cfg_o,
    input logic       commit
);
    // R8: a busy period begins only right after an end-of-transaction pulse
    a_r8_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    // R7: settings hold still while busy
    a_r7_busy_freezes: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ($stable(wiper0_o) && $stable(wiper1_o) && $stable(cfg_o)));

    // R3: the store write closes the busy period
    a_r3_commit_ends_busy: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy_o);

    // R6: the store is written only inside a busy period
    a_r6_commit_inside_busy: assert property (@(posedge clk) disable iff (rst)
        commit |-> busy_o);

    // R2: reserved commands change nothing
    a_r2_reserved_noop: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wr_cmd_i[7:6] == 2'b11) |=>
            ($stable(wiper0_o) && $stable(wiper1_o) && $stable(cfg_o)));
endmodule

bind persist_seq persist_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (wr_i),
    .wr_cmd_i (wr_cmd_i),
    .stop_i   (stop_i),
    .busy_o   (busy_o),
    .wiper0_o (wiper0_o),
    .wiper1_o (wiper1_o),
    .cfg_o    (cfg_o),
    .commit   (commit)
);

// File: tb/persist_seq_bench.sv
`timescale 1ns/1ps
module persist_seq_bench;
    localparam int BUSY = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       blank = 1'b1;
    logic       wr = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic       stop = 1'b0;
    logic       zc = 1'b0;
    logic       busy_o;
    logic [5:0] w0_o, w1_o;
    logic [7:0] cfg_o;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit model_on = 0;
    bit done = 0;

    // behavioural reference state
    int m_w0 = 33, m_w1 = 33, m_ctl = 7;
    int a_w0 = 0, a_w1 = 0, a_ctl = 0;
    bit a_ok = 0;
    int m_phase = 0, m_cnt = 0;
    bit d_tap = 0, d_ctl = 0;

    always #2.5 clk = ~clk;

    persist_seq #(.BUSY_CYC(BUSY)) u_persist_seq (
        .clk(clk), .rst(rst), .blank_i(blank), .wr_i(wr), .wr_cmd_i(cmd),
        .stop_i(stop), .zc_wait_i(zc), .busy_o(busy_o),
        .wiper0_o(w0_o), .wiper1_o(w1_o), .cfg_o(cfg_o)
    );

    function automatic int mute_of(int ctl);
        return ((ctl & 1) != 0) ? 33 : 63;
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int old_ctl;
        bit was_busy, hw, hc, need;
        if (rst) begin
            if (a_ok) begin
                m_ctl = a_ctl;
                if ((a_ctl & 4) != 0) begin
                    m_w0 = mute_of(a_ctl); m_w1 = mute_of(a_ctl);
                end else begin
                    m_w0 = a_w0; m_w1 = a_w1;
                end
            end else begin
                m_ctl = 7; m_w0 = 33; m_w1 = 33;
            end
            m_phase = 0; m_cnt = 0; d_tap = 0; d_ctl = 0;
            if (blank) a_ok = 0;
        end else begin
            old_ctl = m_ctl;
            was_busy = (m_phase != 0);
            hw = 0; hc = 0;
            if (wr && !was_busy) begin
                case (cmd[7:6])
                    2'b00: begin m_w0 = cmd[5:0]; hw = 1; end
                    2'b01: begin m_w1 = cmd[5:0]; hw = 1; end
                    2'b10: begin m_ctl = cmd[2:0]; hc = 1; end
                    default: ;
                endcase
            end
            need = (d_ctl || hc) || ((d_tap || hw) && ((old_ctl & 4) == 0));
            if (m_phase == 0) begin
                if (stop && need)
                    m_phase = (((old_ctl & 2) != 0) && zc) ? 1 : 2;
                m_cnt = BUSY - 1;
            end else if (m_phase == 1) begin
                if (!(((old_ctl & 2) != 0) && zc)) begin
                    m_phase = 2; m_cnt = BUSY - 1;
                end
            end else begin
                if (m_cnt == 0) begin
                    a_w0 = m_w0; a_w1 = m_w1; a_ctl = m_ctl; a_ok = 1;
                    m_phase = 0;
                end else begin
                    m_cnt--;
                end
            end
            if (stop) begin d_tap = 0; d_ctl = 0; end
            else begin d_tap = d_tap || hw; d_ctl = d_ctl || hc; end
            if (blank) a_ok = 0;
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            chk("R3 busy vs model", int'(busy_o), int'(m_phase != 0));
            chk("R2 wiper0 vs model", int'(w0_o), m_w0);
            chk("R2 wiper1 vs model", int'(w1_o), m_w1);
            chk("R6 cfg vs model", int'(cfg_o), 128 + m_ctl);
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            nerr++; nchk++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 50000);
            summary();
            $finish;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(logic [7:0] c);
        wr = 1'b1; cmd = c;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_o && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic power_up(bit blank_store);
        rst = 1'b1; blank = blank_store;
        step(3);
        rst = 1'b0; blank = 1'b0;
        step(1);
    endtask

    initial begin
        int n;
        @(negedge clk);
        power_up(1'b1);
        model_on = 1;
        // R1 blank store defaults
        chk("R1 cfg default", int'(cfg_o), 8'h87);
        chk("R1 wiper0 mute", int'(w0_o), 33);
        chk("R1 wiper1 mute", int'(w1_o), 33);
        chk("R1 not busy", int'(busy_o), 0);

        // R2 decode, R11 control write commits
        do_write(8'h80);
        step(1);
        chk("R2 cfg write", int'(cfg_o), 8'h80);
        do_write(8'h0A);
        do_write(8'h54);
        do_write(8'hC5);
        step(1);
        chk("R2 wiper0 write", int'(w0_o), 10);
        chk("R2 wiper1 write", int'(w1_o), 20);
        chk("R2 reserved ignored", int'(cfg_o), 8'h80);

        // R3 exact busy length, R7 write during busy dropped
        do_stop();
        chk("R3 busy after stop", int'(busy_o), 1);
        do_write(8'h01);
        count_busy(n);
        chk("R3 busy length", n + 1, BUSY);
        chk("R7 busy write ignored", int'(w0_o), 10);

        // R6 reload all three fields
        power_up(1'b0);
        chk("R6 cfg restored", int'(cfg_o), 8'h80);
        chk("R6 wiper0 restored", int'(w0_o), 10);
        chk("R6 wiper1 restored", int'(w1_o), 20);

        // R8 stop without writes, and after reserved only
        do_stop();
        chk("R8 idle stop", int'(busy_o), 0);
        do_write(8'hFF);
        do_stop();
        chk("R8 reserved stop", int'(busy_o), 0);

        // R5 zero-cross wait
        do_write(8'h82);
        do_stop();
        count_busy(n);
        chk("R11 ctl commit length", n, BUSY);
        do_write(8'h05);
        zc = 1'b1;
        do_stop();
        step(30);
        chk("R5 held by zc", int'(busy_o), 1);
        zc = 1'b0;
        count_busy(n);
        chk("R5 length after zc", n, BUSY + 1);

        // R10 zc ignored when disabled
        do_write(8'h80);
        do_stop();
        count_busy(n);
        do_write(8'h07);
        zc = 1'b1;
        do_stop();
        count_busy(n);
        chk("R10 zc ignored", n, BUSY);
        zc = 1'b0;

        // R4 volatile skips tap-only copies, R9 mute reload
        do_write(8'h84);
        do_stop();
        count_busy(n);
        chk("R11 volatile ctl commit", n, BUSY);
        do_write(8'h09);
        do_stop();
        chk("R4 no busy in volatile", int'(busy_o), 0);
        step(2);
        chk("R4 still idle", int'(busy_o), 0);
        power_up(1'b0);
        chk("R9 cfg volatile fine", int'(cfg_o), 8'h84);
        chk("R9 wiper0 mute fine", int'(w0_o), 63);
        chk("R9 wiper1 mute fine", int'(w1_o), 63);
        do_write(8'h85);
        do_stop();
        count_busy(n);
        power_up(1'b0);
        chk("R9 wiper0 mute coarse", int'(w0_o), 33);
        chk("R9 cfg volatile coarse", int'(cfg_o), 8'h85);

        step(2);
        done = 1;
        summary();
        $finish;
    end
endmodule